// File: doc/BRIEF.md
# Configurable Header Bit Extractor

This streaming unit takes packet headers one word at a time from an input stream. It assembles each header and cuts one field out of it. The field can be up to 32 bits wide, and a host picks its lowest and highest bit positions when it starts a run. The unit then sends the field on an output stream. The work is split over three registered stages: assembly, extraction and writing. While one header is being assembled, the previous one is extracted and an older result is written, all in the same cycle.

The host starts a run with a pulse and a pair of bit indices, and can end intake early with a stop pulse. It can watch the run status, the intake status, the pending-output status and a configuration error flag. The output side sends a word only when the sink reports buffer space. Before it sends the next word, it waits for the sink to acknowledge completion of the previous one. Once intake has ended and every complete header has been written, the unit raises an end-of-stream level.

Top module: `hdr_bit_extract`

## Requirements
- R1: After reset, `active`, `read_busy`, `write_busy`, `cfg_err`, `in_take`, `out_valid` and `out_eos` are all low.
- R2: Header bit i is bit (i mod 32) of the (i div 32)-th word received, counting from word 0. For a header, `out_data` bit j equals header bit (lo+j) for j <= hi-lo, and bits above hi-lo are zero.
- R3: A start whose pair has hi < lo, hi-lo >= 32, or hi >= header bits is rejected. It sets `cfg_err`, leaves `active` and `read_busy` low, and takes no input word. A later accepted start clears `cfg_err`.
- R4: `in_take` is high only while `read_busy` is high, `in_avail` is high and `in_eos` is low. Each high cycle consumes `in_data`.
- R5: An accepted start raises `read_busy` and `active` in the next cycle. `read_busy` falls after a cycle with `in_eos` high or `cmd_stop` high.
- R6: `out_valid` is high only in a cycle with `sready` high. After a cycle with `out_valid` high, it stays low until `cready` has been seen high.
- R7: `out_eos` rises once intake has ended and every complete header's field has been sent and acknowledged. It is never high while a result is pending, and an accepted start clears it.
- R8: Under any stall pattern on `in_avail`, `sready` and `cready`, every complete header yields exactly one field, in arrival order.
- R9: Words of a header left incomplete when intake ends, by stop or by end-of-stream, are discarded without output. Complete headers still drain.
- R10: A start pulse while `active` is high is ignored. The bit pair latched at the accepted start stays in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Host pulse: begin a run with `cfg_lo`/`cfg_hi` |
| cmd_stop | input | 1 | Host pulse: end intake, drop partial header |
| cfg_lo | input | IDX_W (8) | Lowest extracted header bit |
| cfg_hi | input | IDX_W (8) | Highest extracted header bit |
| in_avail | input | 1 | Input stream has a word ready |
| in_data | input | WORD_W (32) | Input stream word |
| in_eos | input | 1 | Input stream has ended |
| in_take | output | 1 | Word consumed this cycle |
| out_valid | output | 1 | Output word sent this cycle |
| out_data | output | FIELD_W (32) | Extracted field |
| out_eos | output | 1 | Run finished, all fields written |
| sready | input | 1 | Output buffer can accept a word |
| cready | input | 1 | Previous output word completed |
| active | output | 1 | Run in progress |
| read_busy | output | 1 | Intake in progress |
| write_busy | output | 1 | Results pending in the pipeline |
| cfg_err | output | 1 | Last start was rejected |

## Verification
Word-aligned fields are tried first. They tell a wrong word ordering apart from a wrong shift. Fields that straddle a word boundary expose concatenation errors. Narrow fields at the top of the header expose missing zero-extension and mask mistakes. Free-flowing runs are compared with runs where input gaps, sink back-pressure and slow completions overlap. The stalled runs catch lost or duplicated headers and any word sent before its acknowledgement. A trailing partial header, an early stop, a rejected bit pair and a start issued mid-run each test the control path.

// File: rtl/hbx_pkg.sv
package hbx_pkg;
  localparam int HBX_WORD_W    = 32;
  localparam int HBX_HDR_WORDS = 4;
  localparam int HBX_FIELD_W   = 32;

  // legal pair: ordered, at most fld_w wide, inside the header
  function automatic logic pair_ok(input int lo, input int hi,
                                   input int hdr_bits, input int fld_w);
    return (hi >= lo) && ((hi - lo) < fld_w) && (hi < hdr_bits);
  endfunction
endpackage

// File: rtl/hbx_reader.sv
module hbx_reader #(
  parameter int WORD_W    = 32,
  parameter int HDR_WORDS = 4,
  localparam int HDR_BITS = WORD_W * HDR_WORDS,
  localparam int CNT_W    = $clog2(HDR_WORDS) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                flush,
  input  logic                in_avail,
  input  logic [WORD_W-1:0]   in_data,
  input  logic                in_eos,
  input  logic                down_take,
  output logic                in_take,
  output logic                hdr_full,
  output logic [HDR_BITS-1:0] hdr_data
);
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] slot [HDR_WORDS];
  logic              last_word;

  assign in_take   = enable && in_avail && !in_eos && (!hdr_full || down_take);
  assign last_word = (cnt == CNT_W'(HDR_WORDS - 1));

  for (genvar g = 0; g < HDR_WORDS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                slot[g] <= '0;
      else if (in_take && cnt == CNT_W'(g))      slot[g] <= in_data;
    end
    assign hdr_data[g*WORD_W +: WORD_W] = slot[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      hdr_full <= 1'b0;
    end else begin
      if (down_take) hdr_full <= 1'b0;
      if (flush) cnt <= '0;
      else if (in_take) begin
        if (last_word) begin
          cnt      <= '0;
          hdr_full <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hbx_extract.sv
module hbx_extract #(
  parameter int HDR_BITS = 128,
  parameter int FIELD_W  = 32,
  parameter int IDX_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hdr_full,
  input  logic [HDR_BITS-1:0] hdr_data,
  input  logic [IDX_W-1:0]    lo,
  input  logic [IDX_W-1:0]    hi,
  input  logic                w_free,
  output logic                up_take,
  output logic                x_move,
  output logic [FIELD_W-1:0]  x_data
);
  logic x_full;

  function automatic logic [FIELD_W-1:0] pick(input logic [HDR_BITS-1:0] h,
                                               input logic [IDX_W-1:0] l,
                                               input logic [IDX_W-1:0] u);
    logic [HDR_BITS-1:0] sh;
    logic [FIELD_W-1:0]  f;
    sh = h >> l;
    for (int i = 0; i < FIELD_W; i++)
      f[i] = (i <= int'(u) - int'(l)) ? sh[i] : 1'b0;
    return f;
  endfunction

  assign x_move  = x_full && w_free;
  assign up_take = hdr_full && (!x_full || x_move);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_full <= 1'b0;
      x_data <= '0;
    end else if (up_take) begin
      x_full <= 1'b1;
      x_data <= pick(hdr_data, lo, hi);
    end else if (x_move) begin
      x_full <= 1'b0;
    end
  end
endmodule

// File: rtl/hbx_writer.sv
module hbx_writer #(
  parameter int FIELD_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               x_move,
  input  logic [FIELD_W-1:0] x_data,
  input  logic               sready,
  input  logic               cready,
  output logic               w_free,
  output logic               out_valid,
  output logic [FIELD_W-1:0] out_data,
  output logic               w_busy
);
  logic w_full, w_wait;

  assign out_valid = w_full && !w_wait && sready;
  assign w_free    = !w_full || out_valid;
  assign w_busy    = w_full || w_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_full   <= 1'b0;
      w_wait   <= 1'b0;
      out_data <= '0;
    end else begin
      if (x_move) begin
        w_full   <= 1'b1;
        out_data <= x_data;
      end else if (out_valid) begin
        w_full <= 1'b0;
      end
      if (out_valid)   w_wait <= 1'b1;
      else if (cready) w_wait <= 1'b0;
    end
  end
endmodule

// File: rtl/hdr_bit_extract.sv
module hdr_bit_extract
  import hbx_pkg::*;
#(
  parameter int WORD_W    = HBX_WORD_W,
  parameter int HDR_WORDS = HBX_HDR_WORDS,
  parameter int FIELD_W   = HBX_FIELD_W,
  localparam int HDR_BITS = WORD_W * HDR_WORDS,
  localparam int IDX_W    = $clog2(HDR_BITS) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_start,
  input  logic               cmd_stop,
  input  logic [IDX_W-1:0]   cfg_lo,
  input  logic [IDX_W-1:0]   cfg_hi,
  input  logic               in_avail,
  input  logic [WORD_W-1:0]  in_data,
  input  logic               in_eos,
  output logic               in_take,
  output logic               out_valid,
  output logic [FIELD_W-1:0] out_data,
  output logic               out_eos,
  input  logic               sready,
  input  logic               cready,
  output logic               active,
  output logic               read_busy,
  output logic               write_busy,
  output logic               cfg_err
);
  logic [IDX_W-1:0]    lo_q, hi_q;
  logic                start_ok, start_bad, intake_end;
  logic                hdr_full, a_move, x_move, w_free, w_busy;
  logic [HDR_BITS-1:0] hdr_data;
  logic [FIELD_W-1:0]  x_data;

  assign start_ok   = cmd_start && !active &&  pair_ok(int'(cfg_lo), int'(cfg_hi), HDR_BITS, FIELD_W);
  assign start_bad  = cmd_start && !active && !pair_ok(int'(cfg_lo), int'(cfg_hi), HDR_BITS, FIELD_W);
  assign intake_end = read_busy && (cmd_stop || in_eos);
  assign write_busy = hdr_full || x_move || w_busy || !w_free || u_ext.up_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      read_busy <= 1'b0;
      cfg_err   <= 1'b0;
      out_eos   <= 1'b0;
      lo_q      <= '0;
      hi_q      <= '0;
    end else if (start_ok) begin
      active    <= 1'b1;
      read_busy <= 1'b1;
      cfg_err   <= 1'b0;
      out_eos   <= 1'b0;
      lo_q      <= cfg_lo;
      hi_q      <= cfg_hi;
    end else begin
      if (start_bad)  cfg_err   <= 1'b1;
      if (intake_end) read_busy <= 1'b0;
      if (active && !read_busy && !write_busy) begin
        active  <= 1'b0;
        out_eos <= 1'b1;
      end
    end
  end

  hbx_reader #(.WORD_W(WORD_W), .HDR_WORDS(HDR_WORDS)) u_rd (
    .clk(clk), .rst_n(rst_n), .enable(read_busy && !cmd_stop), .flush(intake_end),
    .in_avail(in_avail), .in_data(in_data), .in_eos(in_eos), .down_take(a_move),
    .in_take(in_take), .hdr_full(hdr_full), .hdr_data(hdr_data));

  hbx_extract #(.HDR_BITS(HDR_BITS), .FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .hdr_full(hdr_full), .hdr_data(hdr_data),
    .lo(lo_q), .hi(hi_q), .w_free(w_free), .up_take(a_move), .x_move(x_move),
    .x_data(x_data));

  hbx_writer #(.FIELD_W(FIELD_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .x_move(x_move), .x_data(x_data), .sready(sready),
    .cready(cready), .w_free(w_free), .out_valid(out_valid), .out_data(out_data),
    .w_busy(w_busy));
endmodule

// File: rtl/hbx_checker.sv
module hbx_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_start,
  input logic in_take,
  input logic in_avail,
  input logic in_eos,
  input logic read_busy,
  input logic out_valid,
  input logic sready,
  input logic cready,
  input logic out_eos,
  input logic write_busy,
  input logic cfg_err,
  input logic active
);
  logic owed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         owed <= 1'b0;
    else if (out_valid) owed <= 1'b1;
    else if (cready)    owed <= 1'b0;
  end

  assert_take_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_take |-> (read_busy && in_avail && !in_eos));
  assert_send_needs_space_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> sready);
  assert_send_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !owed);
  assert_eos_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_eos |-> (!write_busy && !owed));
  assert_intake_from_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_busy) |-> $past(cmd_start));
  assert_bad_pair_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !active);
endmodule

bind hdr_bit_extract hbx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .in_take(in_take),
  .in_avail(in_avail), .in_eos(in_eos), .read_busy(read_busy),
  .out_valid(out_valid), .sready(sready), .cready(cready), .out_eos(out_eos),
  .write_busy(write_busy), .cfg_err(cfg_err), .active(active));

// File: tb/test_hdr_bit_extract.sv
`timescale 1ns/1ps
module test_hdr_bit_extract;
  localparam int CLK_P = 10;
  localparam int HW    = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_start = 0, cmd_stop = 0;
  logic [7:0] cfg_lo = 0, cfg_hi = 0;
  logic in_avail = 0, in_eos = 0, sready = 0, cready = 0;
  logic [31:0] in_data = 0;
  logic in_take, out_valid, out_eos, active, read_busy, write_busy, cfg_err;
  logic [31:0] out_data;

  always #(CLK_P/2) clk = ~clk;

  hdr_bit_extract i_hdr_bit_extract (.*);

  int n_cmp = 0, n_bad = 0, tick = 0;
  logic [31:0] wq[$], asmq[$], expq[$];
  int run_lo = 0, run_hi = 0, stall = 0, ack_gap = 1, ack_cnt = 0;
  bit eos_arm = 0, owed = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ref_field(input logic [31:0] w[$], input int lo, input int hi);
    logic [31:0] r = 0;
    for (int j = 0; j < 32; j++)
      if (j <= hi - lo) r[j] = w[(lo + j) / 32][(lo + j) % 32];
    return r;
  endfunction

  // one clock: drive at negedge, sample 1ns before the rising edge
  task automatic cyc();
    tick++;
    in_avail = (wq.size() > 0) && (stall == 0 || tick % 3 != 0);
    in_data  = (wq.size() > 0) ? wq[0] : 32'h0;
    in_eos   = eos_arm && wq.size() == 0;
    sready   = (stall == 0) || (tick % 5 > 1);
    cready   = (ack_cnt == 1);
    #(CLK_P/2 - 1);
    if (in_take) begin
      chk(read_busy && in_avail && !in_eos, "R4", {29'b0, read_busy, in_avail, in_eos}, 32'h6);
      asmq.push_back(wq.pop_front());
      if (asmq.size() == HW) begin
        expq.push_back(ref_field(asmq, run_lo, run_hi));
        asmq.delete();
      end
    end
    if (cmd_stop || (in_eos && read_busy)) asmq.delete();   // R9 partial drop
    if (out_valid) begin
      chk(!owed && sready, "R6", {30'b0, owed, sready}, 32'h1);
      chk(expq.size() > 0, "R8", expq.size(), 1);
      if (expq.size() > 0) chk(out_data == expq[0], "R2", out_data, expq[0]);
      if (expq.size() > 0) void'(expq.pop_front());
      owed = 1; ack_cnt = ack_gap;
    end else if (cready) begin
      owed = 0; ack_cnt = 0;
    end else if (ack_cnt > 1) ack_cnt--;
    if (out_eos) chk(expq.size() == 0 && !owed, "R7", expq.size(), 0);
    @(negedge clk);
  endtask

  task automatic load(input int hdrs, input int seed);
    for (int k = 0; k < hdrs * HW; k++)
      wq.push_back((32'h9E3779B9 * (k + seed + 1)) ^ (k << 11) ^ seed);
  endtask

  task automatic start(input int lo, input int hi);
    eos_arm = 0;
    cfg_lo = 8'(lo); cfg_hi = 8'(hi); cmd_start = 1;
    cyc();
    cmd_start = 0;
    run_lo = lo; run_hi = hi;
    chk(read_busy && active && !cfg_err && !out_eos, "R5",
        {28'b0, read_busy, active, cfg_err, out_eos}, 32'hC);
  endtask

  task automatic drain(input string req);
    eos_arm = 1;
    for (int k = 0; k < 5000 && !out_eos; k++) cyc();
    chk(out_eos && expq.size() == 0, req, {31'b0, out_eos}, 1);
    chk(!active && !read_busy && !write_busy, "R5", {29'b0, active, read_busy, write_busy}, 0);
  endtask

  initial begin
    #(CLK_P * 190000);
    n_bad++; n_cmp++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(!active && !read_busy && !write_busy && !cfg_err && !in_take && !out_valid && !out_eos,
        "R1", {25'b0, active, read_busy, write_busy, cfg_err, in_take, out_valid, out_eos}, 0);

    // R3 rejected pairs; words waiting must not be taken
    load(1, 7);
    cfg_lo = 10; cfg_hi = 5; cmd_start = 1; cyc(); cmd_start = 0;
    chk(cfg_err && !active && !read_busy, "R3", {29'b0, cfg_err, active, read_busy}, 32'h4);
    cfg_lo = 0; cfg_hi = 32; cmd_start = 1; cyc(); cmd_start = 0;
    chk(cfg_err && !active, "R3", {30'b0, cfg_err, active}, 32'h2);
    cfg_lo = 120; cfg_hi = 128; cmd_start = 1; cyc(); cmd_start = 0;
    repeat (3) cyc();
    chk(cfg_err && !active && wq.size() == HW, "R3", wq.size(), HW);

    // aligned field, free flow
    stall = 0; ack_gap = 1;
    start(0, 31);
    chk(!cfg_err, "R3", {31'b0, cfg_err}, 0);
    load(5, 21);
    drain("R7");

    // straddling field under stalls, start mid-run ignored
    stall = 1; ack_gap = 3;
    start(20, 51);
    load(6, 99);
    repeat (12) cyc();
    cfg_lo = 0; cfg_hi = 7; cmd_start = 1; cyc(); cmd_start = 0;   // R10
    chk(active && !cfg_err, "R10", {30'b0, active, cfg_err}, 32'h2);
    drain("R8");

    // narrow top field with trailing partial header
    stall = 0; ack_gap = 2;
    start(121, 127);
    load(4, 5);
    wq.push_back(32'hFFFF_FFFF); wq.push_back(32'hAAAA_5555);
    drain("R9");

    // early stop
    stall = 1; ack_gap = 1;
    start(64, 95);
    load(8, 44);
    repeat (15) cyc();
    cmd_stop = 1; cyc(); cmd_stop = 0;
    wq.delete();
    chk(!read_busy, "R9", {31'b0, read_busy}, 0);
    drain("R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule